// File: doc/BRIEF.md
# Banked Round, Window and Clamp Output Stage

This block narrows a 20-bit two's complement result from an upstream arithmetic stage to a 13-bit output word. Three operations run in a fixed order: optional rounding at half an output LSB, extraction of one of four 13-bit windows, and clamping between two signed bounds. Out-of-range values are therefore removed before they reach the next stage.

Four configuration banks each hold a rounding enable, a 2-bit window code and a pair of signed 13-bit bounds. A 2-bit selector that travels with each sample chooses the bank used for that sample. Channels or phases that share the stage can therefore use different scalings and legal ranges on consecutive cycles. Banks are loaded through a simple write port. A write takes effect from the following cycle.

Top module: `rsl_stage`

## Requirements
- R1: After reset, out_valid and out_data are 0. Every bank holds rounding off, window code 0, lower bound -4096 and upper bound 4095.
- R2: Window code 0 passes input bits 16:4 to the output, code 1 passes bits 17:5, code 2 passes bits 18:6, and code 3 passes bits 19:7.
- R3: When the bank's rounding enable is 1, 2^(3+code) is added to the sign-extended input before the window is taken. When the enable is 0, the bits below the window are dropped, which gives floor division.
- R4: If the rounded value does not fit the 13-bit window, the value becomes +4095 when positive or -4096 when negative, before the bounds are applied.
- R5: The windowed value is clamped, as a signed number, to no more than the upper bound and no less than the lower bound.
- R6: If the lower bound exceeds the upper bound, the output equals the lower bound.
- R7: The bank is chosen per sample by set_sel. Consecutive samples may use different banks.
- R8: out_valid follows in_valid one cycle later. The result appears in the same cycle. When in_valid is 0, out_data keeps its value.
- R9: A write with wr_en high replaces all four fields of bank wr_set. Samples entered in the following cycle use the new contents, and the other banks are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 20 | Two's complement sample |
| set_sel | input | 2 | Bank used for this sample |
| wr_en | input | 1 | Bank write strobe |
| wr_set | input | 2 | Bank to write |
| wr_rnd_en | input | 1 | Rounding enable to write |
| wr_win | input | 2 | Window code to write |
| wr_lo | input | 13 | Signed lower bound to write |
| wr_hi | input | 13 | Signed upper bound to write |
| out_valid | output | 1 | Result strobe |
| out_data | output | 13 | Signed result |

## Verification
A sample driven at a falling edge is registered at the next rising edge. Its result and out_valid are visible at the falling edge after that, so each result is due exactly one cycle after its stimulus. Bank writes are issued one cycle before the samples that depend on them, matching the one-cycle write latency. The driver computes each expected word and places it in a queue when the sample is applied. The monitor removes one entry at every falling edge where out_valid is high. A result with no queued entry counts as a failure, and so does a queued entry still waiting at the end. This keeps every comparison aligned to the one-cycle latency.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  localparam int RSL_OUT_W = 13;
  localparam int RSL_WIN_W = 2;

  typedef struct packed {
    logic                        rnd_en;
    logic [RSL_WIN_W-1:0]        win;
    logic signed [RSL_OUT_W-1:0] lo;
    logic signed [RSL_OUT_W-1:0] hi;
  } rsl_cfg_t;

  function automatic rsl_cfg_t rsl_cfg_default();
    rsl_cfg_t c;
    c.rnd_en = 1'b0;
    c.win    = '0;
    c.lo     = {1'b1, {(RSL_OUT_W-1){1'b0}}};
    c.hi     = {1'b0, {(RSL_OUT_W-1){1'b1}}};
    return c;
  endfunction
endpackage

// File: rtl/rsl_regbank.sv
module rsl_regbank
  import rsl_pkg::*;
#(
  parameter int NUM_SETS = 4,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  rsl_cfg_t         wr_cfg,
  input  logic [SET_W-1:0] rd_set,
  output rsl_cfg_t         rd_cfg
);
  rsl_cfg_t bank [NUM_SETS];

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst) begin
        bank[g] <= rsl_cfg_default();
      end else if (wr_en && (wr_set == SET_W'(g))) begin
        bank[g] <= wr_cfg;
      end
    end
  end

  assign rd_cfg = bank[rd_set];
endmodule

// File: rtl/rsl_round_select.sv
module rsl_round_select #(
  parameter int IN_W  = 20,
  parameter int OUT_W = 13,
  parameter int BASE  = 4,
  parameter int WIN_W = 2
) (
  input  logic signed [IN_W-1:0]  din,
  input  logic                    rnd_en,
  input  logic [WIN_W-1:0]        win,
  output logic signed [OUT_W-1:0] dout
);
  localparam int SW    = IN_W + 1;
  localparam int N_WIN = 1 << WIN_W;

  logic [SW-1:0]    half;
  logic [SW-1:0]    sum;
  logic [OUT_W-1:0] cand [N_WIN];
  logic             fits [N_WIN];
  logic [OUT_W-1:0] sat_val;

  always_comb begin
    half = '0;
    if (rnd_en) half = SW'(1) << (BASE - 1 + int'(win));
    sum = {din[IN_W-1], din} + half;
  end

  for (genvar k = 0; k < N_WIN; k++) begin : g_win
    localparam int TOP = BASE + k + OUT_W - 1;
    assign cand[k] = sum[BASE+k +: OUT_W];
    assign fits[k] = (&sum[SW-1:TOP]) | ~(|sum[SW-1:TOP]);
  end

  assign sat_val = sum[SW-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                             : {1'b0, {(OUT_W-1){1'b1}}};

  assign dout = fits[win] ? cand[win] : sat_val;
endmodule

// File: rtl/rsl_clamp.sv
module rsl_clamp #(
  parameter int W = 13
) (
  input  logic signed [W-1:0] din,
  input  logic signed [W-1:0] lo,
  input  logic signed [W-1:0] hi,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] capped;

  always_comb begin
    capped = (din > hi) ? hi : din;
    dout   = (capped < lo) ? lo : capped;
  end
endmodule

// File: rtl/rsl_stage.sv
module rsl_stage
  import rsl_pkg::*;
#(
  parameter int IN_W     = 20,
  parameter int OUT_W    = RSL_OUT_W,
  parameter int BASE     = 4,
  parameter int NUM_SETS = 4,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  input  logic [SET_W-1:0]        set_sel,
  input  logic                    wr_en,
  input  logic [SET_W-1:0]        wr_set,
  input  logic                    wr_rnd_en,
  input  logic [RSL_WIN_W-1:0]    wr_win,
  input  logic signed [OUT_W-1:0] wr_lo,
  input  logic signed [OUT_W-1:0] wr_hi,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  rsl_cfg_t            wr_cfg;
  rsl_cfg_t            act_cfg;
  logic signed [OUT_W-1:0] windowed;
  logic signed [OUT_W-1:0] clamped;

  assign wr_cfg = '{rnd_en: wr_rnd_en, win: wr_win, lo: wr_lo, hi: wr_hi};

  rsl_regbank #(.NUM_SETS(NUM_SETS)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_set (wr_set),
    .wr_cfg (wr_cfg),
    .rd_set (set_sel),
    .rd_cfg (act_cfg)
  );

  rsl_round_select #(
    .IN_W (IN_W), .OUT_W(OUT_W), .BASE(BASE), .WIN_W(RSL_WIN_W)
  ) u_rs (
    .din    (in_data),
    .rnd_en (act_cfg.rnd_en),
    .win    (act_cfg.win),
    .dout   (windowed)
  );

  rsl_clamp #(.W(OUT_W)) u_clamp (
    .din  (windowed),
    .lo   (act_cfg.lo),
    .hi   (act_cfg.hi),
    .dout (clamped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= clamped;
    end
  end
endmodule

// File: rtl/rsl_stage_chk.sv
module rsl_stage_chk #(
  parameter int OUT_W    = 13,
  parameter int NUM_SETS = 4,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [SET_W-1:0]        set_sel,
  input logic                    wr_en,
  input logic [SET_W-1:0]        wr_set,
  input logic signed [OUT_W-1:0] wr_lo,
  input logic signed [OUT_W-1:0] wr_hi,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data
);
  logic signed [OUT_W-1:0] sh_lo [NUM_SETS];
  logic signed [OUT_W-1:0] sh_hi [NUM_SETS];
  logic signed [OUT_W-1:0] prev_lo;
  logic signed [OUT_W-1:0] prev_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SETS; i++) begin
        sh_lo[i] <= {1'b1, {(OUT_W-1){1'b0}}};
        sh_hi[i] <= {1'b0, {(OUT_W-1){1'b1}}};
      end
      prev_lo <= {1'b1, {(OUT_W-1){1'b0}}};
      prev_hi <= {1'b0, {(OUT_W-1){1'b1}}};
    end else begin
      if (wr_en) begin
        sh_lo[wr_set] <= wr_lo;
        sh_hi[wr_set] <= wr_hi;
      end
      prev_lo <= sh_lo[set_sel];
      prev_hi <= sh_hi[set_sel];
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data)); // R8
  AST_IN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && prev_lo <= prev_hi) |-> (out_data >= prev_lo && out_data <= prev_hi)); // R5
  AST_INVERTED_LO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && prev_lo > prev_hi) |-> (out_data == prev_lo)); // R6
endmodule

bind rsl_stage rsl_stage_chk #(.OUT_W(OUT_W), .NUM_SETS(NUM_SETS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .set_sel(set_sel),
  .wr_en(wr_en), .wr_set(wr_set), .wr_lo(wr_lo), .wr_hi(wr_hi),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/rsl_stage_tb.sv
module rsl_stage_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [19:0] in_data = '0;
  logic [1:0] set_sel = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_set = '0;
  logic wr_rnd_en = 1'b0;
  logic [1:0] wr_win = '0;
  logic signed [12:0] wr_lo = '0;
  logic signed [12:0] wr_hi = '0;
  logic out_valid;
  logic signed [12:0] out_data;

  int n_run = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];

  bit c_rnd [4];
  int c_win [4];
  int c_lo  [4];
  int c_hi  [4];

  always #2 clk = ~clk;

  rsl_stage u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .set_sel(set_sel), .wr_en(wr_en), .wr_set(wr_set),
    .wr_rnd_en(wr_rnd_en), .wr_win(wr_win), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int model(int x, int s);
    int v;
    int w;
    v = x;
    if (c_rnd[s]) v = v + (1 << (3 + c_win[s]));
    w = v >>> (4 + c_win[s]);
    if (w > 4095) w = 4095;
    if (w < -4096) w = -4096;
    if (w > c_hi[s]) w = c_hi[s];
    if (w < c_lo[s]) w = c_lo[s];
    return w;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int s, bit rnd, int win, int lo, int hi);
    @(negedge clk);
    in_valid = 1'b0;
    wr_en = 1'b1; wr_set = 2'(s); wr_rnd_en = rnd; wr_win = 2'(win);
    wr_lo = 13'(lo); wr_hi = 13'(hi);
    c_rnd[s] = rnd; c_win[s] = win; c_lo[s] = lo; c_hi[s] = hi;
  endtask

  task automatic send(int x, int s, string tag);
    @(negedge clk);
    wr_en = 1'b0;
    in_valid = 1'b1; in_data = 20'(x); set_sel = 2'(s);
    exp_q.push_back(model(x, s));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; wr_en = 1'b0;
    end
  endtask

  // monitor: one queued entry per result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected result", 1, 0);
      end else begin
        check(tag_q.pop_front(), int'(out_data), exp_q.pop_front());
      end
    end
  end

  initial begin
    int held;
    for (int i = 0; i < 4; i++) begin
      c_rnd[i] = 1'b0; c_win[i] = 0; c_lo[i] = -4096; c_hi[i] = 4095;
    end
    repeat (3) @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 data after reset", int'(out_data), 0);
    rst = 1'b0;
    send(291, 0, "R1 default bank");
    send(-43981, 3, "R1 default bank neg");
    idle(1);
    // R2 windows
    wr(0, 0, 0, -4096, 4095);
    wr(1, 0, 1, -4096, 4095);
    wr(2, 0, 2, -4096, 4095);
    wr(3, 0, 3, -4096, 4095);
    send(43981, 0, "R2 win0");
    send(43981, 1, "R2 win1");
    send(43981, 2, "R2 win2");
    send(43981, 3, "R2 win3");
    send(-43981, 1, "R2 win1 neg");
    send(-43981, 3, "R2 win3 neg");
    // R4 saturation
    send(524287, 0, "R4 pos sat");
    send(-524288, 0, "R4 neg sat");
    send(524287, 3, "R4 win3 fits");
    send(-524288, 3, "R4 win3 neg fits");
    // R3 rounding, R9 write then immediate use
    wr(0, 1, 0, -4096, 4095);
    wr(1, 1, 1, -4096, 4095);
    wr(3, 1, 3, -4096, 4095);
    send(8, 0, "R3 round up");
    send(7, 0, "R3 round down");
    send(-8, 0, "R3 round neg half");
    send(-9, 0, "R3 round neg");
    send(31, 1, "R3 round win1");
    send(524287, 3, "R3 R4 round into sat");
    send(43981, 2, "R9 other bank untouched");
    // R5 / R6 limits, R7 bank alternation
    wr(2, 0, 0, -100, 200);
    wr(3, 0, 0, 300, -300);
    send(8000, 2, "R5 upper clamp");
    send(-8000, 2, "R5 lower clamp");
    send(800, 2, "R5 inside");
    send(0, 3, "R6 inverted");
    send(-80000, 3, "R6 inverted neg");
    send(8000, 0, "R7 bank0");
    send(8000, 2, "R7 bank2");
    send(8000, 3, "R7 bank3");
    send(8000, 1, "R7 bank1");
    idle(1);
    held = int'(out_data);
    // R8 hold while idle
    @(negedge clk);
    in_data = 20'sd12345; set_sel = 2'd0;
    idle(3);
    check("R8 valid low idle", int'(out_valid), 0);
    check("R8 data held", int'(out_data), held);
    check("R8 queue drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule